// File: doc/BRIEF.md
# Periodic SPI Slot Sequencer

This block runs repeated bursts of SPI words without any processor work. It keeps a table of transmit words and a matching table of receive words, one entry per slot. A mask vector with one bit per slot chooses which slots take part in a burst. Slots are served from the lowest index upward, and slots whose bit is clear produce no transfer at all. A burst is started either by an internal period timer or by a rising edge on an external trigger input. Each selected word goes to a separate shift engine through a request/acknowledge pair. The word returned with the acknowledge is stored in the receive table at the same slot.

While a burst runs, the chip-select lines can carry a dedicated active-low burst pattern. Between bursts they carry the idle pattern. A programmable gap of idle cycles can be placed between consecutive words. When a burst ends, a one-cycle done pulse fires and a ready flag reports that a full set of receive slots can be read. A trigger that arrives while a burst is still in progress is dropped and recorded in a sticky overrun flag.

The controller is one state machine with six states. S_IDLE is the stopped state. S_ARMED waits for a start event. S_SEEK looks for the first selected slot. S_XFER holds a request until it is acknowledged. S_GAP counts the idle time between words. S_DONE lasts one cycle and closes the burst. The transitions are:
- S_IDLE to S_ARMED once the master enable and at least one run bit are set.
- S_ARMED to S_IDLE when the run condition drops.
- S_ARMED to S_SEEK on a start event.
- S_SEEK to S_XFER when a selected slot exists, and S_SEEK to S_DONE when none does.
- On acknowledge, S_XFER stays in S_XFER for the next slot when the gap is zero, goes to S_GAP for the next slot when the gap is not zero, and goes to S_DONE when no selected slot is left.
- S_GAP to S_XFER when the gap count expires.
- S_DONE to S_ARMED while running, or to S_IDLE otherwise.

Top module: `periodic_spi_seq`

## Requirements
- R1: After reset, xfer_req, burst_busy, burst_done, rx_ready and overrun are 0, and cs_n equals cs_idle.
- R2: While auto_en is 0, no burst starts: neither the timer nor ext_trig causes burst_busy or xfer_req.
- R3: A burst requests every slot whose slot_mask bit is 1, in ascending index order, exactly once. xfer_data is the transmit-table word of that slot. xfer_data stays stable while a request waits for its acknowledge.
- R4: The word on xfer_rdata at each acknowledge is written to the receive-table entry of that slot. Receive entries of unselected slots keep their previous contents.
- R5: rx_ready is cleared when a burst starts and is set in the cycle after the one-cycle burst_done pulse. Each burst produces exactly one burst_done pulse.
- R6: With run_timer=1, run_ext=0 and period=P (P>=1), consecutive bursts start exactly P clock cycles apart.
- R7: With run_ext=1, a burst starts on each rising edge of ext_trig. The period timer is ignored even if run_timer is also 1.
- R8: Within a burst of N words, xfer_req is low for exactly 1 + (N-1)*gap_len*GAP_UNIT cycles while burst_busy is high. With gap_len=0, consecutive words follow back to back.
- R9: With auto_cs_en=1, cs_n equals cs_burst while burst_busy is high. In every other case cs_n equals cs_idle.
- R10: A start event during a burst is dropped: no extra burst follows. The same event sets overrun, which stays set until the sequencer stops.
- R11: A burst with an all-zero slot_mask issues no request and still produces burst_done and rx_ready.
- R12: Clearing both run_timer and run_ext lets a running burst finish and then returns to S_IDLE. In S_IDLE, rx_ready and overrun are cleared and no further bursts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Master enable for automated bursts |
| run_timer | input | 1 | Start bursts from the period timer |
| run_ext | input | 1 | Start bursts from ext_trig rising edges (takes precedence) |
| ext_trig | input | 1 | External start trigger |
| period | input | PER_W | Clock cycles between timer-started bursts |
| gap_len | input | GAP_W | Gap between words, in units of GAP_UNIT cycles |
| auto_cs_en | input | 1 | Drive cs_burst during bursts |
| cs_burst | input | CS_W | Chip-select pattern used during a burst |
| cs_idle | input | CS_W | Chip-select pattern used otherwise |
| slot_mask | input | NSLOTS | One bit per slot; 1 selects the slot |
| tx_wr_en | input | 1 | Transmit-table write strobe |
| tx_wr_idx | input | clog2(NSLOTS) | Transmit-table write slot |
| tx_wr_data | input | WORD_W | Transmit-table write word |
| rx_rd_idx | input | clog2(NSLOTS) | Receive-table read slot |
| rx_rd_data | output | WORD_W | Receive-table word at rx_rd_idx |
| xfer_req | output | 1 | Word request to the shift engine |
| xfer_data | output | WORD_W | Word to shift out |
| xfer_ack | input | 1 | Shift engine done with the current word |
| xfer_rdata | input | WORD_W | Word shifted in, valid with xfer_ack |
| cs_n | output | CS_W | Chip-select lines |
| burst_busy | output | 1 | Burst in progress |
| burst_done | output | 1 | One-cycle pulse at the end of a burst |
| rx_ready | output | 1 | A complete receive set is available |
| overrun | output | 1 | Sticky: a start event arrived during a burst |

## Verification
The bench builds the block with 8 slots of 8-bit words, a 4-line chip select, an 8-bit period and GAP_UNIT of 2. With these values every slot, including the highest, is reached in a few dozen cycles. A full mask, a sparse mask and an empty mask each fit in one short burst. Gap timing, timer spacing and overrun by a second trigger in mid-burst can then be measured as exact cycle counts well inside the run length.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_SEEK,
        S_XFER,
        S_GAP,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt;
    logic             last;

    assign last = (period <= PER_W'(1)) || (cnt >= period - PER_W'(1));
    assign tick = en && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PER_W'(1);
        end
    end

    // R6: with a period above one, two ticks never fall in adjacent cycles
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period > PER_W'(1) && $stable(period)) |=> !tick);
endmodule

// File: rtl/seq_scan.sv
module seq_scan #(
    parameter int N  = 128,
    parameter int SW = 7,
    parameter int IW = 8
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] from,
    output logic          hit,
    output logic [SW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (IW'(i) >= from)) begin
                hit = 1'b1;
                idx = SW'(i);
            end
        end
    end
endmodule

// File: rtl/seq_table.sv
module seq_table #(
    parameter int DEPTH = 128,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/periodic_spi_seq.sv
module periodic_spi_seq
    import seq_pkg::*;
#(
    parameter int NSLOTS   = 128,
    parameter int WORD_W   = 32,
    parameter int PER_W    = 16,
    parameter int GAP_W    = 5,
    parameter int GAP_UNIT = 4,
    parameter int CS_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      auto_en,
    input  logic                      run_timer,
    input  logic                      run_ext,
    input  logic                      ext_trig,
    input  logic [PER_W-1:0]          period,
    input  logic [GAP_W-1:0]          gap_len,
    input  logic                      auto_cs_en,
    input  logic [CS_W-1:0]           cs_burst,
    input  logic [CS_W-1:0]           cs_idle,
    input  logic [NSLOTS-1:0]         slot_mask,
    input  logic                      tx_wr_en,
    input  logic [$clog2(NSLOTS)-1:0] tx_wr_idx,
    input  logic [WORD_W-1:0]         tx_wr_data,
    input  logic [$clog2(NSLOTS)-1:0] rx_rd_idx,
    output logic [WORD_W-1:0]         rx_rd_data,
    output logic                      xfer_req,
    output logic [WORD_W-1:0]         xfer_data,
    input  logic                      xfer_ack,
    input  logic [WORD_W-1:0]         xfer_rdata,
    output logic [CS_W-1:0]           cs_n,
    output logic                      burst_busy,
    output logic                      burst_done,
    output logic                      rx_ready,
    output logic                      overrun
);
    localparam int SW  = $clog2(NSLOTS);
    localparam int IW  = SW + 1;
    localparam int GCW = GAP_W + $clog2(GAP_UNIT) + 1;

    seq_state_e     state, state_nx;
    logic [SW-1:0]  cur, cur_nx;
    logic [GCW-1:0] gcnt, gcnt_nx;
    logic           rdy_q, ovr_q, trig_q;
    logic           run_on, tmr_tick, ext_fire, fire, in_burst;
    logic           scan_hit;
    logic [SW-1:0]  scan_idx;
    logic [IW-1:0]  scan_from;
    logic           rx_we;

    assign run_on   = auto_en && (run_timer || run_ext);
    assign ext_fire = auto_en && run_ext && ext_trig && !trig_q;
    assign fire     = ext_fire || tmr_tick;
    assign in_burst = (state == S_SEEK) || (state == S_XFER) ||
                      (state == S_GAP)  || (state == S_DONE);

    seq_timer #(.PER_W(PER_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (auto_en && run_timer && !run_ext),
        .period (period),
        .tick   (tmr_tick)
    );

    assign scan_from = (state == S_XFER) ? (IW'(cur) + IW'(1)) : '0;

    seq_scan #(.N(NSLOTS), .SW(SW), .IW(IW)) u_scan (
        .mask (slot_mask),
        .from (scan_from),
        .hit  (scan_hit),
        .idx  (scan_idx)
    );

    assign rx_we = (state == S_XFER) && xfer_ack;

    seq_table #(.DEPTH(NSLOTS), .W(WORD_W)) u_txtab (
        .clk   (clk),
        .we    (tx_wr_en),
        .waddr (tx_wr_idx),
        .wdata (tx_wr_data),
        .raddr (cur),
        .rdata (xfer_data)
    );

    seq_table #(.DEPTH(NSLOTS), .W(WORD_W)) u_rxtab (
        .clk   (clk),
        .we    (rx_we),
        .waddr (cur),
        .wdata (xfer_rdata),
        .raddr (rx_rd_idx),
        .rdata (rx_rd_data)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        cur_nx   = cur;
        gcnt_nx  = gcnt;
        unique case (state)
            S_IDLE: begin
                if (run_on) state_nx = S_ARMED;
            end
            S_ARMED: begin
                if (!run_on) state_nx = S_IDLE;
                else if (fire) state_nx = S_SEEK;
            end
            S_SEEK: begin
                if (scan_hit) begin
                    state_nx = S_XFER;
                    cur_nx   = scan_idx;
                end else begin
                    state_nx = S_DONE;
                end
            end
            S_XFER: begin
                if (xfer_ack) begin
                    if (scan_hit) begin
                        cur_nx = scan_idx;
                        if (gap_len != '0) begin
                            state_nx = S_GAP;
                            gcnt_nx  = GCW'(gap_len) * GCW'(GAP_UNIT);
                        end
                    end else begin
                        state_nx = S_DONE;
                    end
                end
            end
            S_GAP: begin
                if (gcnt <= GCW'(1)) state_nx = S_XFER;
                else gcnt_nx = gcnt - GCW'(1);
            end
            S_DONE: begin
                state_nx = run_on ? S_ARMED : S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // state register and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cur    <= '0;
            gcnt   <= '0;
            rdy_q  <= 1'b0;
            ovr_q  <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            state  <= state_nx;
            cur    <= cur_nx;
            gcnt   <= gcnt_nx;
            trig_q <= ext_trig;
            if (state == S_IDLE) begin
                rdy_q <= 1'b0;
                ovr_q <= 1'b0;
            end else begin
                if (state == S_DONE) rdy_q <= 1'b1;
                else if (state == S_ARMED && run_on && fire) rdy_q <= 1'b0;
                if (fire && in_burst) ovr_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        xfer_req   = (state == S_XFER);
        burst_busy = (state == S_SEEK) || (state == S_XFER) || (state == S_GAP);
        burst_done = (state == S_DONE);
        cs_n       = (auto_cs_en && burst_busy) ? cs_burst : cs_idle;
        rx_ready   = rdy_q;
        overrun    = ovr_q;
    end

    // R3: a pending request holds its word until acknowledged
    a_r3_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack && !tx_wr_en) |=> (xfer_req && $stable(xfer_data)));

    // R3: after an acknowledge the slot index only moves upward, or the burst closes
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack) |=> (burst_done || (cur > $past(cur))));

    // R5: the done pulse lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);

    // R5: ready only rises right after a done pulse
    a_r5_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(burst_done));

    // R8: no request is raised inside a gap
    a_r8_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP) |-> !xfer_req);

    // R10: overrun stays set until the sequencer is idle
    a_r10_overrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && state != S_IDLE) |=> overrun);
endmodule

// File: tb/sim_periodic_spi_seq.sv
module sim_periodic_spi_seq;
    localparam int NS  = 8;
    localparam int WW  = 8;
    localparam int PW  = 8;
    localparam int GW  = 3;
    localparam int GU  = 2;
    localparam int CW  = 4;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_en = 1'b0, run_timer = 1'b0, run_ext = 1'b0, ext_trig = 1'b0;
    logic [PW-1:0] period = '0;
    logic [GW-1:0] gap_len = '0;
    logic auto_cs_en = 1'b0;
    logic [CW-1:0] cs_burst = 4'b1101;
    logic [CW-1:0] cs_idle  = 4'b1111;
    logic [NS-1:0] slot_mask = '0;
    logic tx_wr_en = 1'b0;
    logic [2:0] tx_wr_idx = '0;
    logic [WW-1:0] tx_wr_data = '0;
    logic [2:0] rx_rd_idx = '0;
    logic [WW-1:0] rx_rd_data;
    logic xfer_req;
    logic [WW-1:0] xfer_data;
    logic xfer_ack = 1'b0;
    logic [WW-1:0] xfer_rdata = '0;
    logic [CW-1:0] cs_n;
    logic burst_busy, burst_done, rx_ready, overrun;

    periodic_spi_seq #(.NSLOTS(NS), .WORD_W(WW), .PER_W(PW), .GAP_W(GW),
                       .GAP_UNIT(GU), .CS_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .run_timer(run_timer),
        .run_ext(run_ext), .ext_trig(ext_trig), .period(period), .gap_len(gap_len),
        .auto_cs_en(auto_cs_en), .cs_burst(cs_burst), .cs_idle(cs_idle),
        .slot_mask(slot_mask), .tx_wr_en(tx_wr_en), .tx_wr_idx(tx_wr_idx),
        .tx_wr_data(tx_wr_data), .rx_rd_idx(rx_rd_idx), .rx_rd_data(rx_rd_data),
        .xfer_req(xfer_req), .xfer_data(xfer_data), .xfer_ack(xfer_ack),
        .xfer_rdata(xfer_rdata), .cs_n(cs_n), .burst_busy(burst_busy),
        .burst_done(burst_done), .rx_ready(rx_ready), .overrun(overrun)
    );

    always #2 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    bit finished = 0;
    logic [WW-1:0] txm [NS];
    logic [WW-1:0] exp_q [$];
    int n_xfer = 0, n_bursts = 0, n_done = 0;
    int rise_last = 0, rise_prev = 0;
    int lowc = 0, last_low = 0;
    int wait_cnt = 0, cs_bad = 0, dbl_done = 0;
    bit busy_prev = 0, done_prev = 0;
    logic [CW-1:0] exp_cs_busy = 4'b1101;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // shift engine model, scoreboard monitor and burst bookkeeping
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (burst_busy && !busy_prev) begin
                rise_prev = rise_last;
                rise_last = cyc;
                n_bursts++;
            end
            if (burst_busy && !xfer_req) lowc++;
            if (burst_done) begin
                last_low = lowc;
                lowc = 0;
                n_done++;
                if (done_prev) dbl_done++;
            end
            if (burst_busy && cs_n != exp_cs_busy) cs_bad++;
            if (!burst_busy && cs_n != cs_idle) cs_bad++;
            if (xfer_ack) begin
                xfer_ack = 1'b0;
            end else if (xfer_req) begin
                if (wait_cnt == LAT) begin
                    xfer_ack   = 1'b1;
                    xfer_rdata = xfer_data ^ 8'hA5;
                    wait_cnt   = 0;
                    n_xfer++;
                    if (exp_q.size() == 0) begin
                        chk(0, "R3 unexpected transfer", int'(xfer_data), -1);
                    end else begin
                        logic [WW-1:0] e;
                        e = exp_q.pop_front();
                        chk(xfer_data == e, "R3 slot order/data", int'(xfer_data), int'(e));
                    end
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
            busy_prev = burst_busy;
            done_prev = burst_done;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_tx(input int idx, input logic [WW-1:0] d);
        @(negedge clk);
        tx_wr_en = 1'b1; tx_wr_idx = 3'(idx); tx_wr_data = d;
        @(negedge clk);
        tx_wr_en = 1'b0;
        txm[idx] = d;
    endtask

    task automatic push_expected(input logic [NS-1:0] m);
        for (int i = 0; i < NS; i++)
            if (m[i]) exp_q.push_back(txm[i]);
    endtask

    task automatic pulse_trig();
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
    endtask

    task automatic ext_burst(input logic [NS-1:0] m);
        int d0;
        d0 = n_done;
        slot_mask = m;
        push_expected(m);
        @(negedge clk);
        pulse_trig();
        while (n_done == d0) @(negedge clk);
        cycles(1);
    endtask

    function automatic int read_rx_now(input int idx);
        return 0;
    endfunction

    task automatic read_rx(input int idx, output logic [WW-1:0] v);
        @(negedge clk);
        rx_rd_idx = 3'(idx);
        #1;
        v = rx_rd_data;
    endtask

    // watchdog
    always @(negedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] v;
        int x0, b0, d0;
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        chk(cs_n == cs_idle, "R1 cs_n", int'(cs_n), int'(cs_idle));
        chk(!xfer_req && !burst_busy && !burst_done, "R1 req/busy/done", int'({xfer_req, burst_busy, burst_done}), 0);
        chk(!rx_ready && !overrun, "R1 ready/overrun", int'({rx_ready, overrun}), 0);

        for (int i = 0; i < NS; i++) write_tx(i, 8'(8'h10 + i * 7));

        // R2 master enable gate
        run_ext = 1'b1; slot_mask = '1;
        cycles(2); pulse_trig(); cycles(20);
        run_ext = 1'b0; run_timer = 1'b1; period = 8'd5;
        cycles(30);
        chk(n_bursts == 0 && n_xfer == 0, "R2 no burst while disabled", n_bursts + n_xfer, 0);
        run_timer = 1'b0;

        // R3/R4/R5/R8/R9 full mask, no gap, auto chip select
        auto_en = 1'b1; run_ext = 1'b1; auto_cs_en = 1'b1; gap_len = '0;
        exp_cs_busy = cs_burst;
        cycles(2);
        x0 = n_xfer;
        ext_burst(8'hFF);
        chk(n_xfer - x0 == 8, "R3 full mask count", n_xfer - x0, 8);
        chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
        chk(rx_ready == 1'b1, "R5 ready after burst", int'(rx_ready), 1);
        chk(dbl_done == 0, "R5 single done pulse", dbl_done, 0);
        chk(last_low == 1, "R8 back-to-back words", last_low, 1);
        for (int i = 0; i < NS; i++) begin
            read_rx(i, v);
            chk(v == (txm[i] ^ 8'hA5), "R4 rx slot stored", int'(v), int'(txm[i] ^ 8'hA5));
        end

        // R4/R5/R8 sparse mask with gap and new transmit data
        for (int i = 0; i < NS; i++) write_tx(i, 8'(8'h80 + i * 3));
        gap_len = 3'd2;
        d0 = n_done;
        slot_mask = 8'b1010_0101;
        push_expected(8'b1010_0101);
        @(negedge clk);
        pulse_trig();
        while (!burst_busy) @(negedge clk);
        chk(rx_ready == 1'b0, "R5 ready cleared at start", int'(rx_ready), 0);
        while (n_done == d0) @(negedge clk);
        cycles(1);
        chk(exp_q.size() == 0, "R3 sparse queue drained", exp_q.size(), 0);
        chk(last_low == 1 + 3 * 2 * GU, "R8 gap cycles", last_low, 1 + 3 * 2 * GU);
        for (int i = 0; i < NS; i++) begin
            logic [WW-1:0] e;
            e = (8'b1010_0101 >> i) & 1 ? (txm[i] ^ 8'hA5) : (8'(8'h10 + i * 7) ^ 8'hA5);
            read_rx(i, v);
            chk(v == e, "R4 selected updated, unselected kept", int'(v), int'(e));
        end

        // R11 empty mask
        x0 = n_xfer; d0 = n_done;
        ext_burst(8'h00);
        chk(n_xfer == x0, "R11 no request", n_xfer - x0, 0);
        chk(n_done == d0 + 1 && rx_ready, "R11 done and ready", n_done - d0, 1);

        // R10 overrun by a second trigger mid-burst
        gap_len = 3'd3;
        x0 = n_xfer; b0 = n_bursts; d0 = n_done;
        slot_mask = 8'hFF;
        push_expected(8'hFF);
        @(negedge clk);
        pulse_trig();
        cycles(4);
        chk(overrun == 1'b0, "R10 no overrun yet", int'(overrun), 0);
        pulse_trig();
        while (n_done == d0) @(negedge clk);
        cycles(20);
        chk(overrun == 1'b1, "R10 overrun set", int'(overrun), 1);
        chk(n_bursts == b0 + 1, "R10 trigger dropped", n_bursts - b0, 1);
        chk(n_xfer == x0 + 8, "R10 word count", n_xfer - x0, 8);

        // R9 automatic chip select off
        auto_cs_en = 1'b0; exp_cs_busy = cs_idle; gap_len = '0;
        ext_burst(8'h03);
        chk(cs_bad == 0, "R9 chip-select pattern", cs_bad, 0);

        // R7 external mode ignores the timer
        run_timer = 1'b1; period = 8'd6;
        b0 = n_bursts;
        cycles(40);
        chk(n_bursts == b0, "R7 timer ignored in external mode", n_bursts - b0, 0);
        ext_burst(8'h10);
        chk(n_bursts == b0 + 1, "R7 burst on trigger edge", n_bursts - b0, 1);

        // R6 timer spacing
        period = 8'd20; slot_mask = 8'h01;
        push_expected(8'h01); push_expected(8'h01); push_expected(8'h01);
        d0 = n_done;
        run_ext = 1'b0;
        while (n_done < d0 + 3) @(negedge clk);
        run_timer = 1'b0;
        chk(rise_last - rise_prev == 20, "R6 burst spacing", rise_last - rise_prev, 20);
        chk(overrun == 1'b1, "R10 overrun sticky while running", int'(overrun), 1);

        // R12 stop
        cycles(3);
        chk(!rx_ready && !overrun, "R12 flags cleared on stop", int'({rx_ready, overrun}), 0);
        b0 = n_bursts;
        cycles(60);
        chk(n_bursts == b0 && !burst_busy, "R12 no bursts after stop", n_bursts - b0, 0);
        chk(exp_q.size() == 0, "R3 final queue empty", exp_q.size(), 0);
        chk(cs_bad == 0, "R9 chip-select overall", cs_bad, 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule